// File: doc/BRIEF.md
# Synchronized Multi-Output PWM Timer

This block is a timer with one master channel and a parameterized number of slave channels (two by default), all stepping on a shared prescaled tick. The master counts down from a programmed period value and emits a one-cycle period pulse each time it wraps, and also at the moment it is started. Each slave has no period of its own. It is restarted by every master pulse, holds its output active for a programmed number of ticks, and then drives it inactive. The result is several PWM outputs that share one period and one phase origin, each with its own duty.

Software programs the block through a simple single-port write interface. The writable values are the period, one duty value per slave, the per-slave combination-mode bits, polarity bits, output-enable bits and default output levels. A start trigger word and a stop trigger word are also written here, each with one bit per channel. These trigger bits clear themselves one cycle after they are written, so several channels can be started or stopped together with a single write. A run flag per channel shows whether that channel is counting. The block-level enable models the gated clock supply: while it is low, nothing is written and nothing counts.

Register addresses, 4 bits wide:

| Address | Content |
|---|---|
| 0 | period |
| 1+s | duty of slave s |
| 10 | combination-mode bits |
| 11 | default levels (write-only action) |
| 12 | output enables |
| 13 | polarity bits |
| 14 | start triggers |
| 15 | stop triggers |

For the trigger words, bit 0 is the master and bit s+1 is slave s.

Top module: `tpwm_multi`

## Requirements
- R1: After reset, `irq_o`, every bit of `run_o`, every bit of `pwm_o` and every bit of `pwm_oe_o` are 0.
- R2: A write to address 14 is a self-clearing start trigger. A write in cycle n sets `run_o[c]` for each set data bit c (bit 0 master, bit s+1 slave s) from cycle n+2 onward. That one write produces exactly one start.
- R3: A master start written in cycle n gives a one-cycle `irq_o` pulse in cycle n+2. While the master runs and ticks are present, the next pulses follow every period+1 cycles. `irq_o` is never high while `run_o[0]` is low.
- R4: For a running slave with its combination bit (address 10, bit s) set and polarity 0, `pwm_o[s]` is 1 for the duty-value cycles that follow each master pulse cycle, and 0 for the rest of the period.
- R5: A duty of 0 gives a constantly inactive output. A duty greater than the period gives a constantly active output.
- R6: A slave whose combination bit is 0 ignores master pulses, and its output keeps its current level.
- R7: A write to address 11 in cycle n sets `pwm_o[s]` of every stopped slave to data bit s in cycle n+1. A stopped slave's output does not change otherwise.
- R8: `pwm_oe_o[s]` equals bit s of the last value written to address 12. A 0 means the pad is high-impedance.
- R9: A write to address 15 in cycle n clears `run_o[c]` for each set data bit c from cycle n+2. The slave outputs freeze at their current level, even in a cycle where the duty would have expired. A stopped master issues no further pulses.
- R10: Polarity bit s (address 13) inverts the active and inactive levels of `pwm_o[s]`.
- R11: While `blk_en_i` is 0, writes are ignored, `irq_o` stays 0, and `run_o` and `pwm_o` hold their values.
- R12: While `tick_i` is 0, the master does not count and issues no period pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_en_i | input | 1 | Block clock-enable; when low, writes and counting are frozen |
| tick_i | input | 1 | Shared prescaled count tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | DW | Register write data |
| pwm_o | output | NSLV | Slave output levels |
| pwm_oe_o | output | NSLV | Slave output enables (0 = high-impedance pad) |
| run_o | output | NSLV+1 | Run flags: bit 0 master, bit s+1 slave s |
| irq_o | output | 1 | Master period pulse |

## Verification
Two events can land on the same clock edge. One is a slave's own end-of-duty count. The other is either a stop trigger or the master's period reload. The bench writes a stop word whose trigger cycle coincides with the cycle in which a duty-2 slave would drop inactive, and expects the output to stay frozen active afterwards. A slave with duty greater than the period has its expiry overtaken by the master's reload every period, so it is judged by its output never leaving the active level.

// File: rtl/tpwm_pkg.sv
package tpwm_pkg;
   localparam int unsigned ADDR_W = 4;
   localparam logic [ADDR_W-1:0] A_PERIOD = 4'd0;
   localparam logic [ADDR_W-1:0] A_DUTY0  = 4'd1;
   localparam logic [ADDR_W-1:0] A_COMBO  = 4'd10;
   localparam logic [ADDR_W-1:0] A_DFLT   = 4'd11;
   localparam logic [ADDR_W-1:0] A_OE     = 4'd12;
   localparam logic [ADDR_W-1:0] A_POL    = 4'd13;
   localparam logic [ADDR_W-1:0] A_START  = 4'd14;
   localparam logic [ADDR_W-1:0] A_STOP   = 4'd15;

   // Per-slave control bundle passed from the register file
   typedef struct packed {
      logic combo;
      logic pol;
      logic start;
      logic stop;
      logic dflt_ld;
      logic dflt_val;
   } slv_ctl_t;
endpackage

// File: rtl/tpwm_regs.sv
module tpwm_regs
   import tpwm_pkg::*;
#(
   parameter int unsigned NSLV = 2,
   parameter int unsigned CW   = 8,
   parameter int unsigned DW   = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     en_i,
   input  logic                     wr_en_i,
   input  logic [ADDR_W-1:0]        wr_addr_i,
   input  logic [DW-1:0]            wr_data_i,
   output logic [CW-1:0]            period_o,
   output logic [NSLV-1:0][CW-1:0]  duty_o,
   output logic [NSLV-1:0]          combo_o,
   output logic [NSLV-1:0]          pol_o,
   output logic [NSLV-1:0]          oe_o,
   output logic [NSLV:0]            start_o,
   output logic [NSLV:0]            stop_o,
   output logic                     dflt_ld_o,
   output logic [NSLV-1:0]          dflt_val_o
);
   localparam int unsigned NCH = NSLV + 1;

   logic wr_ok;
   logic unused_data;

   assign wr_ok       = en_i & wr_en_i;
   assign dflt_ld_o   = wr_ok && (wr_addr_i == A_DFLT);
   assign dflt_val_o  = wr_data_i[NSLV-1:0];
   assign unused_data = ^wr_data_i;

   // Shared control words and self-clearing trigger words
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_o <= '0;
         combo_o  <= '0;
         pol_o    <= '0;
         oe_o     <= '0;
         start_o  <= '0;
         stop_o   <= '0;
      end else begin
         start_o <= '0;
         stop_o  <= '0;
         if (wr_ok) begin
            case (wr_addr_i)
               A_PERIOD: period_o <= wr_data_i[CW-1:0];
               A_COMBO:  combo_o  <= wr_data_i[NSLV-1:0];
               A_POL:    pol_o    <= wr_data_i[NSLV-1:0];
               A_OE:     oe_o     <= wr_data_i[NSLV-1:0];
               A_START:  start_o  <= wr_data_i[NCH-1:0];
               A_STOP:   stop_o   <= wr_data_i[NCH-1:0];
               default:  ;
            endcase
         end
      end
   end

   // One duty register per slave at consecutive addresses
   for (genvar s = 0; s < NSLV; s++) begin : g_duty
      localparam logic [ADDR_W-1:0] ADDR = ADDR_W'(int'(A_DUTY0) + s);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             duty_o[s] <= '0;
         else if (wr_ok && (wr_addr_i == ADDR))  duty_o[s] <= wr_data_i[CW-1:0];
      end
   end
endmodule

// File: rtl/tpwm_master.sv
module tpwm_master #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          tick_i,
   input  logic          start_i,
   input  logic          stop_i,
   input  logic [CW-1:0] period_i,
   output logic          run_o,
   output logic          irq_o
);
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_o <= 1'b0;
         irq_o <= 1'b0;
      end else if (!en_i) begin
         irq_o <= 1'b0;
      end else begin
         irq_o <= 1'b0;
         if (stop_i) begin
            run_o <= 1'b0;
         end else if (start_i) begin
            run_o <= 1'b1;
            cnt_q <= period_i;
            irq_o <= 1'b1;
         end else if (run_o && tick_i) begin
            if (cnt_q == '0) begin
               cnt_q <= period_i;
               irq_o <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tpwm_slave.sv
module tpwm_slave
   import tpwm_pkg::*;
#(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic          tick_i,
   input  logic          mpulse_i,
   input  logic [CW-1:0] duty_i,
   input  slv_ctl_t      ctl_i,
   output logic          run_o,
   output logic          lvl_o
);
   logic [CW-1:0] cnt_q;
   logic          act_q;
   logic          nz_duty;

   assign nz_duty = (duty_i != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= 1'b0;
         run_o <= 1'b0;
         lvl_o <= 1'b0;
      end else if (en_i) begin
         if (ctl_i.stop) begin
            run_o <= 1'b0;
            act_q <= 1'b0;
         end else begin
            if (ctl_i.start) run_o <= 1'b1;
            // master pulse reloads and outranks the duty expiry
            if (run_o && ctl_i.combo && mpulse_i) begin
               cnt_q <= duty_i;
               act_q <= nz_duty;
               lvl_o <= nz_duty ^ ctl_i.pol;
            end else if (run_o && ctl_i.combo && act_q && tick_i) begin
               if (cnt_q == CW'(1)) begin
                  act_q <= 1'b0;
                  lvl_o <= ctl_i.pol;
               end
               cnt_q <= cnt_q - 1'b1;
            end
         end
         if (!run_o && ctl_i.dflt_ld) lvl_o <= ctl_i.dflt_val;
      end
   end
endmodule

// File: rtl/tpwm_multi.sv
module tpwm_multi
   import tpwm_pkg::*;
#(
   parameter int unsigned NSLV = 2,
   parameter int unsigned CW   = 8,
   parameter int unsigned DW   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              blk_en_i,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [3:0]        wr_addr_i,
   input  logic [DW-1:0]     wr_data_i,
   output logic [NSLV-1:0]   pwm_o,
   output logic [NSLV-1:0]   pwm_oe_o,
   output logic [NSLV:0]     run_o,
   output logic              irq_o
);
   if (NSLV < 1 || NSLV > 8) begin : g_bad_nslv
      $error("tpwm_multi: NSLV must lie in 1..8");
   end
   if (CW < 2) begin : g_bad_cw
      $error("tpwm_multi: CW must be at least 2");
   end
   if (DW < CW || DW < NSLV + 1) begin : g_bad_dw
      $error("tpwm_multi: DW too narrow for counters or trigger words");
   end

   logic [CW-1:0]           period;
   logic [NSLV-1:0][CW-1:0] duty;
   logic [NSLV-1:0]         combo, pol, dflt_val;
   logic [NSLV:0]           start_t, stop_t;
   logic                    dflt_ld;
   logic                    m_run;
   logic [NSLV-1:0]         s_run;

   tpwm_regs #(.NSLV(NSLV), .CW(CW), .DW(DW)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (blk_en_i),
      .wr_en_i    (wr_en_i),
      .wr_addr_i  (wr_addr_i),
      .wr_data_i  (wr_data_i),
      .period_o   (period),
      .duty_o     (duty),
      .combo_o    (combo),
      .pol_o      (pol),
      .oe_o       (pwm_oe_o),
      .start_o    (start_t),
      .stop_o     (stop_t),
      .dflt_ld_o  (dflt_ld),
      .dflt_val_o (dflt_val)
   );

   tpwm_master #(.CW(CW)) u_master (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (blk_en_i),
      .tick_i   (tick_i),
      .start_i  (start_t[0]),
      .stop_i   (stop_t[0]),
      .period_i (period),
      .run_o    (m_run),
      .irq_o    (irq_o)
   );

   for (genvar s = 0; s < NSLV; s++) begin : g_slv
      slv_ctl_t ctl;
      assign ctl = '{combo:    combo[s],
                     pol:      pol[s],
                     start:    start_t[s+1],
                     stop:     stop_t[s+1],
                     dflt_ld:  dflt_ld,
                     dflt_val: dflt_val[s]};
      tpwm_slave #(.CW(CW)) u_slave (
         .clk      (clk),
         .rst_n    (rst_n),
         .en_i     (blk_en_i),
         .tick_i   (tick_i),
         .mpulse_i (irq_o),
         .duty_i   (duty[s]),
         .ctl_i    (ctl),
         .run_o    (s_run[s]),
         .lvl_o    (pwm_o[s])
      );
   end

   assign run_o = {s_run, m_run};
endmodule

module tpwm_chk
   import tpwm_pkg::*;
#(
   parameter int unsigned NSLV = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            blk_en_i,
   input logic            wr_en_i,
   input logic [3:0]      wr_addr_i,
   input logic [NSLV-1:0] pwm_o,
   input logic [NSLV-1:0] pwm_oe_o,
   input logic [NSLV:0]   run_o,
   input logic            irq_o
);
   // R3: a period pulse only comes from a running master
   p_irq_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> run_o[0]);

   // R2: a master start always announces itself with a pulse
   p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_o[0]) |-> irq_o);

   // R11: block disabled freezes state and silences the pulse
   p_en_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_en_i |=> ($stable(run_o) && $stable(pwm_o) && !irq_o));

   // R8: enables move only after an accepted enable write
   p_oe_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pwm_oe_o) |-> $past(blk_en_i && wr_en_i && (wr_addr_i == A_OE)));

   // R7: a stopped slave keeps its level unless a default write lands
   for (genvar s = 0; s < NSLV; s++) begin : g_hold
      p_stopped_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (!run_o[s+1] && !(blk_en_i && wr_en_i && (wr_addr_i == A_DFLT)))
         |=> $stable(pwm_o[s]));
   end
endmodule

bind tpwm_multi tpwm_chk #(.NSLV(NSLV)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .blk_en_i  (blk_en_i),
   .wr_en_i   (wr_en_i),
   .wr_addr_i (wr_addr_i),
   .pwm_o     (pwm_o),
   .pwm_oe_o  (pwm_oe_o),
   .run_o     (run_o),
   .irq_o     (irq_o)
);

// File: tb/tb_tpwm_multi.sv
module tb_tpwm_multi;
   import tpwm_pkg::*;

   localparam int CLK_PER = 10;
   localparam int NSLV = 2;
   localparam int CW   = 8;
   localparam int DW   = 16;
   localparam int K_IRQ = 0, K_RUN = 1, K_PWM = 2, K_OE = 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            blk_en = 1'b1;
   logic            tick = 1'b1;
   logic            wr_en = 1'b0;
   logic [3:0]      wr_addr = '0;
   logic [DW-1:0]   wr_data = '0;
   logic [NSLV-1:0] pwm_o, pwm_oe_o;
   logic [NSLV:0]   run_o;
   logic            irq_o;

   tpwm_multi #(.NSLV(NSLV), .CW(CW), .DW(DW)) dut (
      .clk(clk), .rst_n(rst_n), .blk_en_i(blk_en), .tick_i(tick),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o), .run_o(run_o), .irq_o(irq_o));

   always #(CLK_PER/2) clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int    at;
      int    kind;
      int    idx;
      logic  val;
      string req;
   } exp_t;

   exp_t sb[$];
   int checks = 0;
   int errors = 0;
   bit done = 0;

   function automatic logic obs(int kind, int idx);
      case (kind)
         K_IRQ:   return irq_o;
         K_RUN:   return run_o[idx];
         K_PWM:   return pwm_o[idx];
         default: return pwm_oe_o[idx];
      endcase
   endfunction

   task automatic expect_at(int at, int kind, int idx, logic val, string req);
      exp_t e;
      e.at = at; e.kind = kind; e.idx = idx; e.val = val; e.req = req;
      sb.push_back(e);
   endtask

   // monitor: pops due items and compares them mid-cycle
   always @(negedge clk) begin
      if (!done) begin
         for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at <= cyc) begin
               logic act;
               act = obs(sb[i].kind, sb[i].idx);
               checks++;
               if (sb[i].at < cyc || act !== sb[i].val) begin
                  errors++;
                  $display("FAIL %s cycle %0d kind %0d idx %0d actual %b expected %b",
                           sb[i].req, sb[i].at, sb[i].kind, sb[i].idx, act, sb[i].val);
               end
               sb.delete(i);
            end
         end
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic go_to(int c);
      while (cyc < c) step();
   endtask

   task automatic wr(logic [3:0] a, int d, output int w);
      wr_en = 1'b1; wr_addr = a; wr_data = DW'(d); w = cyc;
      step();
      wr_en = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : driver
      int w, s, d, e, t, o, x;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      expect_at(cyc, K_IRQ, 0, 1'b0, "R1");
      for (int c = 0; c <= NSLV; c++) expect_at(cyc, K_RUN, c, 1'b0, "R1");
      for (int c = 0; c < NSLV; c++) begin
         expect_at(cyc, K_PWM, c, 1'b0, "R1");
         expect_at(cyc, K_OE, c, 1'b0, "R1");
      end
      step();

      // Phase 1: period 4, duty 2 and 7
      wr(A_PERIOD, 4, x);
      wr(A_DUTY0, 2, x);
      wr(A_DUTY0 + 4'd1, 7, x);
      wr(A_COMBO, 3, x);
      wr(A_POL, 0, x);
      wr(A_OE, 3, w);
      expect_at(w+1, K_OE, 0, 1'b1, "R8");
      expect_at(w+1, K_OE, 1, 1'b1, "R8");
      wr(A_DFLT, 2, w);
      expect_at(w+1, K_PWM, 0, 1'b0, "R7");
      expect_at(w+1, K_PWM, 1, 1'b1, "R7");
      wr(A_START, 7, w);
      expect_at(w+1, K_IRQ, 0, 1'b0, "R3");
      expect_at(w+1, K_RUN, 0, 1'b0, "R2");
      expect_at(w+2, K_IRQ, 0, 1'b1, "R3");
      for (int c = 0; c <= NSLV; c++) expect_at(w+2, K_RUN, c, 1'b1, "R2");
      expect_at(w+3, K_IRQ, 0, 1'b0, "R2");
      expect_at(w+6, K_IRQ, 0, 1'b0, "R3");
      expect_at(w+7, K_IRQ, 0, 1'b1, "R3");
      expect_at(w+2, K_PWM, 0, 1'b0, "R4");
      expect_at(w+3, K_PWM, 0, 1'b1, "R4");
      expect_at(w+4, K_PWM, 0, 1'b1, "R4");
      expect_at(w+5, K_PWM, 0, 1'b0, "R4");
      expect_at(w+7, K_PWM, 0, 1'b0, "R4");
      expect_at(w+8, K_PWM, 0, 1'b1, "R4");
      expect_at(w+3, K_PWM, 1, 1'b1, "R5");
      expect_at(w+7, K_PWM, 1, 1'b1, "R5");
      expect_at(w+8, K_PWM, 1, 1'b1, "R5");

      // Phase 2: stop collides with slave 0 duty expiry
      go_to(w+8);
      wr(A_STOP, 7, s);
      for (int c = 0; c <= NSLV; c++) begin
         expect_at(s+1, K_RUN, c, 1'b1, "R9");
         expect_at(s+2, K_RUN, c, 1'b0, "R9");
      end
      expect_at(s+2, K_PWM, 0, 1'b1, "R9");
      expect_at(s+6, K_PWM, 0, 1'b1, "R9");
      expect_at(s+4, K_PWM, 1, 1'b1, "R9");
      expect_at(s+4, K_IRQ, 0, 1'b0, "R9");

      // Phase 3: default levels while stopped
      go_to(s+8);
      wr(A_DFLT, 2, d);
      expect_at(d+1, K_PWM, 0, 1'b0, "R7");
      expect_at(d+1, K_PWM, 1, 1'b1, "R7");
      expect_at(d+5, K_PWM, 0, 1'b0, "R7");

      // Phase 4: polarity on slave 0, slave 1 out of combination mode
      go_to(d+6);
      wr(A_COMBO, 1, x);
      wr(A_POL, 1, x);
      wr(A_DUTY0 + 4'd1, 3, x);
      wr(A_START, 7, w);
      expect_at(w+2, K_PWM, 0, 1'b0, "R10");
      expect_at(w+3, K_PWM, 0, 1'b0, "R10");
      expect_at(w+4, K_PWM, 0, 1'b0, "R10");
      expect_at(w+5, K_PWM, 0, 1'b1, "R10");
      expect_at(w+6, K_PWM, 0, 1'b1, "R10");
      expect_at(w+3, K_PWM, 1, 1'b1, "R6");
      expect_at(w+6, K_PWM, 1, 1'b1, "R6");
      expect_at(w+7, K_PWM, 1, 1'b1, "R6");
      expect_at(w+7, K_IRQ, 0, 1'b1, "R3");
      go_to(w+3);
      wr(A_DUTY0, 0, x);
      expect_at(w+8, K_PWM, 0, 1'b1, "R5");
      expect_at(w+9, K_PWM, 0, 1'b1, "R5");
      expect_at(w+12, K_PWM, 0, 1'b1, "R5");
      expect_at(w+13, K_PWM, 0, 1'b1, "R5");

      // Phase 5: block enable off
      go_to(w+14);
      e = cyc;
      blk_en = 1'b0;
      step();
      wr(A_OE, 0, x);
      expect_at(e+2, K_OE, 0, 1'b1, "R11");
      expect_at(e+6, K_OE, 1, 1'b1, "R11");
      expect_at(e+3, K_IRQ, 0, 1'b0, "R11");
      expect_at(e+8, K_IRQ, 0, 1'b0, "R11");
      expect_at(e+5, K_RUN, 0, 1'b1, "R11");
      expect_at(e+5, K_RUN, 1, 1'b1, "R11");
      expect_at(e+5, K_PWM, 0, 1'b1, "R11");
      go_to(e+10);
      blk_en = 1'b1;

      // Phase 6: no ticks
      go_to(e+12);
      t = cyc;
      tick = 1'b0;
      expect_at(t+2, K_IRQ, 0, 1'b0, "R12");
      expect_at(t+6, K_IRQ, 0, 1'b0, "R12");
      expect_at(t+10, K_IRQ, 0, 1'b0, "R12");
      go_to(t+12);
      tick = 1'b1;

      // Phase 7: disable one output
      wr(A_OE, 1, o);
      expect_at(o+1, K_OE, 1, 1'b0, "R8");
      expect_at(o+1, K_OE, 0, 1'b1, "R8");
      go_to(o+4);
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL scoreboard actual %0d pending expected 0", sb.size());
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule